// File: doc/BRIEF.md
# Page-Pair Translation Rights Checker

This block takes one translation entry that an earlier lookup has already matched and produces three results from it: the physical address, the read, write and execute permissions for the page, and a result code. One entry covers two adjacent pages, an even page and an odd page. Each of the two halves has its own frame number and its own rights. The virtual address bit at the page-size position chooses which half applies. The page size comes from the entry when the entry belongs to the variable-size region, and from a global page-size value when it belongs to the fixed-size region.

The rights checks run in a fixed priority order, so that exactly one reason is reported for a fault. The privilege check has two modes. The normal mode lets any level at or below the page's level numerically pass. The restricted mode passes only on an exact level match. In 32-bit mode the no-execute, no-read and restricted bits of the half are ignored. The logic is purely combinational and has no clock.

Top module: `pte_perm_chk`

## Requirements
- R1: The effective page size exponent is `ent_ps_i` when `var_region_i` is 1, and `glob_ps_i` when it is 0. It must lie between 12 and VA_W-2.
- R2: Bit number "effective exponent" of `va_i` selects the half. A 0 selects `half_even_i` and a 1 selects `half_odd_i`.
- R3: Half layout: bit 0 valid, bit 1 dirty, bits 3:2 page level, bit 4 no-execute, bit 5 no-read, bit 6 restricted-level, and bits from 7 upward the frame number (PA_W-12 bits). If valid is 0, `res_o` is 1 (invalid) whatever the other fields hold.
- R4: A valid half with `acc_i`=0 (fetch) and no-execute set gives `res_o`=2 (execute-inhibit).
- R5: Otherwise, `acc_i`=1 (load) with no-read set gives `res_o`=3 (read-inhibit).
- R6: Otherwise, with restricted-level 0, a `plv_i` numerically greater than the page level gives `res_o`=4 (privilege).
- R7: Otherwise, with restricted-level 1, any `plv_i` different from the page level gives `res_o`=4.
- R8: Otherwise, `acc_i`=2 (store) with dirty clear gives `res_o`=5 (dirty). All remaining cases give `res_o`=0 (match).
- R9: On a match, `pa_o` is the frame number with its bits below position (exponent-12) cleared, shifted left by 12, OR'd with the bits of `va_i` below the exponent.
- R10: On a match, `perm_r_o` is 1, `perm_w_o` equals the dirty bit, and `perm_x_o` is the inverse of the no-execute bit.
- R11: When `mode64_i` is 0, the no-execute, no-read and restricted-level bits are treated as 0.
- R12: When `res_o` is not 0, `pa_o` and all three permission outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| va_i | input | VA_W | Virtual address |
| acc_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| plv_i | input | 2 | Current privilege level |
| mode64_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| var_region_i | input | 1 | Entry comes from the variable-size region |
| ent_ps_i | input | PS_W | Page size exponent stored in the entry |
| glob_ps_i | input | PS_W | Global page size exponent for the fixed region |
| half_even_i | input | PA_W-5 | Even-page half-entry |
| half_odd_i | input | PA_W-5 | Odd-page half-entry |
| pa_o | output | PA_W | Physical address |
| perm_r_o | output | 1 | Read permitted |
| perm_w_o | output | 1 | Write permitted |
| perm_x_o | output | 1 | Execute permitted |
| res_o | output | 3 | Result code 0..5 |

## Verification
The bench sweeps every combination of the seven rights bits, every access kind, every privilege level, both modes, both size regions and three page sizes. It drives the unused half with the complement of the selected one, so that picking the wrong half or the wrong exponent shows up at once as a wrong code or a wrong address. A design that reorders the priority chain would report, for example, dirty where no-read is expected. A design that swaps the two privilege rules would fail every restricted case with a lower level. A design that forgets the 32-bit masking would raise execute-inhibit faults in 32-bit mode. A design that misplaces the software-bit clear would leak frame bits into the page offset, and this shows only at the larger page sizes.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;
  localparam int F_V    = 0;
  localparam int F_D    = 1;
  localparam int F_PLV  = 2;
  localparam int F_NX   = 4;
  localparam int F_NR   = 5;
  localparam int F_RPLV = 6;
  localparam int F_PPN  = 7;

  typedef enum logic [2:0] {
    RES_MATCH = 3'd0,
    RES_INVAL = 3'd1,
    RES_XINH  = 3'd2,
    RES_RINH  = 3'd3,
    RES_PRIV  = 3'd4,
    RES_DIRTY = 3'd5
  } res_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;
endpackage

// File: rtl/pte_half_sel.sv
module pte_half_sel
  import pte_chk_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PS_W   = 6,
  parameter int HALF_W = 43
) (
  input  logic [VA_W-1:0]   va_i,
  input  logic              var_region_i,
  input  logic [PS_W-1:0]   ent_ps_i,
  input  logic [PS_W-1:0]   glob_ps_i,
  input  logic [HALF_W-1:0] half_even_i,
  input  logic [HALF_W-1:0] half_odd_i,
  output logic [PS_W-1:0]   ps_o,
  output logic              odd_o,
  output logic [HALF_W-1:0] half_o
);
  logic [VA_W-1:0] va_sh;

  always_comb begin
    ps_o   = var_region_i ? ent_ps_i : glob_ps_i;
    va_sh  = va_i >> ps_o;
    odd_o  = va_sh[0];
    half_o = odd_o ? half_odd_i : half_even_i;
  end

  always_comb begin
    if (!$isunknown({va_i, half_even_i, half_odd_i, ent_ps_i, glob_ps_i, var_region_i})) begin
      // R2
      half_pick_chk: assert (half_o == (odd_o ? half_odd_i : half_even_i))
        else $error("half select mismatch");
      // R1
      ps_src_chk: assert (ps_o == ent_ps_i || ps_o == glob_ps_i)
        else $error("page size source mismatch");
    end
  end
endmodule

// File: rtl/pte_rights_chk.sv
module pte_rights_chk
  import pte_chk_pkg::*;
(
  input  logic [1:0] acc_i,
  input  logic [1:0] plv_i,
  input  logic       mode64_i,
  input  logic       v_i,
  input  logic       d_i,
  input  logic [1:0] ent_plv_i,
  input  logic       nx_raw_i,
  input  logic       nr_raw_i,
  input  logic       rplv_raw_i,
  output logic [2:0] res_o,
  output logic       perm_r_o,
  output logic       perm_w_o,
  output logic       perm_x_o
);
  logic nx, nr, rplv, priv_bad;
  res_e res;

  always_comb begin
    // 32-bit mode ignores extended rights bits
    nx       = nx_raw_i   & mode64_i;
    nr       = nr_raw_i   & mode64_i;
    rplv     = rplv_raw_i & mode64_i;
    priv_bad = rplv ? (plv_i != ent_plv_i) : (plv_i > ent_plv_i);
    if (!v_i)                                res = RES_INVAL;
    else if (acc_i == ACC_FETCH && nx)       res = RES_XINH;
    else if (acc_i == ACC_LOAD && nr)        res = RES_RINH;
    else if (priv_bad)                       res = RES_PRIV;
    else if (acc_i == ACC_STORE && !d_i)     res = RES_DIRTY;
    else                                     res = RES_MATCH;
    res_o    = res;
    perm_r_o = (res == RES_MATCH);
    perm_w_o = (res == RES_MATCH) & d_i;
    perm_x_o = (res == RES_MATCH) & ~nx;
  end

  always_comb begin
    if (!$isunknown({acc_i, plv_i, mode64_i, v_i, d_i, ent_plv_i, nx_raw_i, nr_raw_i, rplv_raw_i})) begin
      // R3
      inval_first_chk: assert (v_i || res_o == RES_INVAL)
        else $error("invalid not first");
      // R4
      xinh_fetch_chk: assert (res_o != RES_XINH || acc_i == ACC_FETCH)
        else $error("execute-inhibit on non-fetch");
      // R5
      rinh_load_chk: assert (res_o != RES_RINH || acc_i == ACC_LOAD)
        else $error("read-inhibit on non-load");
      // R8
      dirty_store_chk: assert (res_o != RES_DIRTY || (acc_i == ACC_STORE && !d_i))
        else $error("dirty fault on wrong access");
      // R11
      narrow_mode_chk: assert (mode64_i || (res_o != RES_XINH && res_o != RES_RINH))
        else $error("extended fault in 32-bit mode");
    end
  end
endmodule

// File: rtl/pte_pa_gen.sv
module pte_pa_gen #(
  parameter int VA_W  = 48,
  parameter int PA_W  = 48,
  parameter int PS_W  = 6,
  parameter int PPN_W = 36
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic [PPN_W-1:0] ppn_i,
  input  logic             en_i,
  output logic [PA_W-1:0]  pa_o
);
  localparam int AW = (VA_W > PA_W) ? VA_W : PA_W;

  logic [PS_W-1:0]  sw_cnt;
  logic [PPN_W-1:0] ppn_clr;
  logic [AW-1:0]    va_ext, off, pa_full;

  always_comb begin
    sw_cnt  = ps_i - PS_W'(12);
    // software bits occupy frame bits below the page size
    ppn_clr = ppn_i & ~((PPN_W'(1) << sw_cnt) - PPN_W'(1));
    va_ext  = AW'(va_i);
    off     = va_ext & ((AW'(1) << ps_i) - AW'(1));
    pa_full = AW'({ppn_clr, 12'h000}) | off;
    pa_o    = en_i ? pa_full[PA_W-1:0] : '0;
  end

  always_comb begin
    if (!$isunknown({va_i, ps_i, ppn_i, en_i})) begin
      // R9
      low_off_chk: assert (!en_i || pa_o[11:0] == va_ext[11:0])
        else $error("page offset not carried");
      // R12
      pa_quiet_chk: assert (en_i || pa_o == '0)
        else $error("address leaks on fault");
    end
  end
endmodule

// File: rtl/pte_perm_chk.sv
module pte_perm_chk
  import pte_chk_pkg::*;
#(
  parameter int  VA_W   = 48,
  parameter int  PA_W   = 48,
  localparam int PS_W   = $clog2(VA_W),
  localparam int PPN_W  = PA_W - 12,
  localparam int HALF_W = F_PPN + PPN_W
) (
  input  logic [VA_W-1:0]   va_i,
  input  logic [1:0]        acc_i,
  input  logic [1:0]        plv_i,
  input  logic              mode64_i,
  input  logic              var_region_i,
  input  logic [PS_W-1:0]   ent_ps_i,
  input  logic [PS_W-1:0]   glob_ps_i,
  input  logic [HALF_W-1:0] half_even_i,
  input  logic [HALF_W-1:0] half_odd_i,
  output logic [PA_W-1:0]   pa_o,
  output logic              perm_r_o,
  output logic              perm_w_o,
  output logic              perm_x_o,
  output logic [2:0]        res_o
);
  logic [PS_W-1:0]   ps;
  logic              odd;
  logic [HALF_W-1:0] half;

  pte_half_sel #(.VA_W(VA_W), .PS_W(PS_W), .HALF_W(HALF_W)) u_sel (
    .va_i         (va_i),
    .var_region_i (var_region_i),
    .ent_ps_i     (ent_ps_i),
    .glob_ps_i    (glob_ps_i),
    .half_even_i  (half_even_i),
    .half_odd_i   (half_odd_i),
    .ps_o         (ps),
    .odd_o        (odd),
    .half_o       (half)
  );

  pte_rights_chk u_rights (
    .acc_i      (acc_i),
    .plv_i      (plv_i),
    .mode64_i   (mode64_i),
    .v_i        (half[F_V]),
    .d_i        (half[F_D]),
    .ent_plv_i  (half[F_PLV +: 2]),
    .nx_raw_i   (half[F_NX]),
    .nr_raw_i   (half[F_NR]),
    .rplv_raw_i (half[F_RPLV]),
    .res_o      (res_o),
    .perm_r_o   (perm_r_o),
    .perm_w_o   (perm_w_o),
    .perm_x_o   (perm_x_o)
  );

  pte_pa_gen #(.VA_W(VA_W), .PA_W(PA_W), .PS_W(PS_W), .PPN_W(PPN_W)) u_pa (
    .va_i  (va_i),
    .ps_i  (ps),
    .ppn_i (half[F_PPN +: PPN_W]),
    .en_i  (res_o == RES_MATCH),
    .pa_o  (pa_o)
  );

  always_comb begin
    if (!$isunknown({va_i, acc_i, plv_i, mode64_i, var_region_i, ent_ps_i, glob_ps_i,
                     half_even_i, half_odd_i})) begin
      // R10
      read_on_match_chk: assert (perm_r_o == (res_o == RES_MATCH))
        else $error("read permission disagrees with result");
      // R12
      perm_quiet_chk: assert (res_o == RES_MATCH || !(perm_w_o || perm_x_o))
        else $error("permissions on fault");
      // R6
      priv_normal_chk: assert (!(res_o == RES_MATCH && !(mode64_i && half[F_RPLV]))
                               || plv_i <= half[F_PLV +: 2])
        else $error("lower level passed normal check");
      // R7
      priv_exact_chk: assert (!(res_o == RES_MATCH && mode64_i && half[F_RPLV])
                              || plv_i == half[F_PLV +: 2])
        else $error("restricted level mismatch passed");
    end
  end
endmodule

// File: tb/tb_pte_perm_chk.sv
module tb_pte_perm_chk;
  localparam int VA_W = 16;
  localparam int PA_W = 20;
  localparam int PS_W = $clog2(VA_W);
  localparam int PPN_W = PA_W - 12;
  localparam int HALF_W = 7 + PPN_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [VA_W-1:0]   va;
  logic [1:0]        acc, plv;
  logic              m64, vreg;
  logic [PS_W-1:0]   eps, gps;
  logic [HALF_W-1:0] he, ho;
  logic [PA_W-1:0]   pa;
  logic              pr, pw, px;
  logic [2:0]        res;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  pte_perm_chk #(.VA_W(VA_W), .PA_W(PA_W)) dut (
    .va_i(va), .acc_i(acc), .plv_i(plv), .mode64_i(m64), .var_region_i(vreg),
    .ent_ps_i(eps), .glob_ps_i(gps), .half_even_i(he), .half_odd_i(ho),
    .pa_o(pa), .perm_r_o(pr), .perm_w_o(pw), .perm_x_o(px), .res_o(res)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // all-zero inputs: invalid half, no address, no rights
    va = '0; acc = 2'd1; plv = 2'd0; m64 = 1'b1; vreg = 1'b1;
    eps = PS_W'(12); gps = PS_W'(12); he = '0; ho = '0;
    @(negedge clk); #2;
    chk("R3 idle code", 32'(res), 32'd1);
    chk("R12 idle pa", 32'(pa), 32'd0);
    chk("R12 idle perms", 32'({pr, pw, px}), 32'd0);

    for (int pi = 0; pi < 3; pi++)
      for (int rg = 0; rg < 2; rg++)
        for (int md = 0; md < 2; md++)
          for (int ac = 0; ac < 3; ac++)
            for (int cp = 0; cp < 4; cp++)
              for (int f = 0; f < 128; f++)
                for (int vs = 0; vs < 2; vs++) begin
                  int e_ps, bit_v, bit_d, bit_nx, bit_nr, bit_rp, ent_l, code;
                  logic [PPN_W-1:0] ppn, ppn_c;
                  logic [HALF_W-1:0] sel;
                  logic [31:0] e_pa;
                  logic [VA_W-1:0] v;
                  string tag;
                  e_ps = rg ? 12 + pi : 12 + ((pi + 1) % 3);
                  v = vs ? (16'hB5A7 ^ 16'(f << 6) ^ 16'(cp << 3))
                         : (16'h4A58 ^ 16'(f << 8) ^ 16'(ac));
                  ppn = 8'h5C ^ 8'(f * 3);
                  sel = {ppn, 7'(f)};
                  @(negedge clk);
                  va = v; acc = 2'(ac); plv = 2'(cp); m64 = 1'(md); vreg = 1'(rg);
                  eps = PS_W'(12 + pi); gps = PS_W'(12 + ((pi + 1) % 3));
                  // R2: selected half by va bit at the exponent, other half complemented
                  if (v[e_ps]) begin ho = sel; he = ~sel; end
                  else begin he = sel; ho = ~sel; end
                  #2;
                  bit_v = f & 1; bit_d = (f >> 1) & 1; ent_l = (f >> 2) & 3;
                  bit_nx = md ? (f >> 4) & 1 : 0;       // R11
                  bit_nr = md ? (f >> 5) & 1 : 0;
                  bit_rp = md ? (f >> 6) & 1 : 0;
                  if (!bit_v) begin code = 1; tag = "R3"; end
                  else if (ac == 0 && bit_nx) begin code = 2; tag = "R4"; end
                  else if (ac == 1 && bit_nr) begin code = 3; tag = "R5"; end
                  else if (bit_rp == 0 && cp > ent_l) begin code = 4; tag = "R6"; end
                  else if (bit_rp == 1 && cp != ent_l) begin code = 4; tag = "R7"; end
                  else if (ac == 2 && !bit_d) begin code = 5; tag = "R8"; end
                  else begin code = 0; tag = md ? "R8 match" : "R11 match"; end
                  chk({tag, " R1 R2 code"}, 32'(res), 32'(code));
                  ppn_c = ppn & ~8'((1 << (e_ps - 12)) - 1);
                  e_pa = (32'(ppn_c) << 12) | (32'(v) & ((32'd1 << e_ps) - 1));
                  if (code == 0) begin
                    chk("R9 R1 R2 pa", 32'(pa), e_pa);
                    chk("R10 perms", 32'({pr, pw, px}), 32'({1'b1, 1'(bit_d), 1'(!bit_nx)}));
                  end else begin
                    chk("R12 pa", 32'(pa), 32'd0);
                    chk("R12 perms", 32'({pr, pw, px}), 32'd0);
                  end
                end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule